// File: doc/BRIEF.md
# Transmit Double-Buffer Ownership Controller

This block arbitrates two transmit buffer slots that live in a larger packet RAM and are shared by two parties. The producer, an upper-level framing agent, fills one slot and hands it over with a submit request that carries the frame length. The transmitter, a lower-level sender, is told to start on a slot and later reports completion. While the transmitter works on one slot, the producer fills the other. Each completion gives the slot back to the producer, and the producer receives a notification that names the slot.

The block keeps a small ownership state for each slot: producer-owned, queued, or sending. It enforces strict alternation, so slots are submitted and sent in the order 0, 1, 0, 1, and the transmitter never holds more than one frame. It also gives the transmitter the RAM byte address of the slot it must send. Slot size, RAM size and the RAM buffer indices used for the two slots are parameters.

Top module: `tpp_ctrl`

## Requirements
- R1: After reset, prod_slot is 0, tx_busy is 0, and sub_ack, sub_err, tx_start and note_done are all 0. Both slots are producer-owned.
- R2: At most one slot is in the sending state. tx_start is issued only when tx_busy is 0 or tx_done is sampled in the same cycle. tx_busy is 1 from the tx_start cycle until the cycle after the matching tx_done.
- R3: A submit (sub_req=1) is accepted when sub_slot equals prod_slot, that slot is producer-owned, and 1 <= sub_len <= SLOT_BYTES (4096 by default). Acceptance gives a one-cycle sub_ack in the next cycle, and prod_slot toggles in that same cycle.
- R4: Any other submit is rejected. sub_err pulses for one cycle in the next cycle, prod_slot does not change, and no tx_start results.
- R5: A submit that names the slot currently being sent is rejected as in R4.
- R6: An accepted slot is started when the transmitter is free. tx_start is a one-cycle pulse that comes no earlier than the cycle after sub_ack. It carries tx_slot, the submitted length on tx_len, and tx_addr = RAM buffer index × SLOT_BYTES. With the defaults, slot 0 uses buffer 0 (address 0) and slot 1 uses buffer 1 (address 4096).
- R7: Slots are started in strict alternation, beginning with slot 0.
- R8: When tx_done=1 while tx_busy=1, note_done pulses for one cycle in the next cycle, note_slot gives the completed slot, and that slot returns to the producer.
- R9: If the other slot was already accepted when tx_done arrives, its tx_start appears in the cycle after tx_done, the same cycle as note_done.
- R10: tx_done while tx_busy=0 is ignored: no note_done, and tx_busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_req | input | 1 | Producer submit request, sampled each cycle |
| sub_slot | input | 1 | Slot being submitted |
| sub_len | input | LEN_W | Frame length in bytes |
| sub_ack | output | 1 | Submit accepted (one-cycle pulse) |
| sub_err | output | 1 | Submit rejected (one-cycle pulse) |
| prod_slot | output | 1 | Slot the producer must fill next |
| tx_start | output | 1 | Start strobe toward the transmitter |
| tx_slot | output | 1 | Slot to send |
| tx_len | output | LEN_W | Length of the frame to send |
| tx_addr | output | ADDR_W | RAM byte address of the slot base |
| tx_done | input | 1 | Transmitter completion strobe |
| tx_busy | output | 1 | A frame is held by the transmitter |
| note_done | output | 1 | Completion notification to the producer |
| note_slot | output | 1 | Slot that completed |

## Verification
The assertions check on every cycle that at most one slot is sending, that a start needs a free transmitter and a queued slot, that ack and error never coincide, that a slot is released only from the sending state, and that a stray completion makes no notification. Exact timing cannot be seen from single cycles: the one-cycle latency from submit to ack, the back-to-back restart after a completion, the alternation order, and the length and address carried through. The bench scenarios show these by comparing every output, on every cycle, against an ownership model that is stepped from the same stimulus.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
   typedef enum logic [1:0] {
      SL_FILL    = 2'd0,
      SL_QUEUED  = 2'd1,
      SL_SENDING = 2'd2
   } slot_st_e;

   function automatic logic [1:0] slot_onehot(input logic idx);
      return idx ? 2'b10 : 2'b01;
   endfunction
endpackage

// File: rtl/tpp_admit.sv
module tpp_admit #(
   parameter int LEN_W      = 13,
   parameter int SLOT_BYTES = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sub_req,
   input  logic             sub_slot,
   input  logic [LEN_W-1:0] sub_len,
   input  logic [1:0]       fill_vec,
   output logic [1:0]       acc_vec,
   output logic             sub_ack,
   output logic             sub_err,
   output logic             prod_slot
);
   import tpp_pkg::*;

   localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(SLOT_BYTES);

   logic len_ok;
   logic owner_ok;
   logic accept;

   always_comb begin
      len_ok   = (sub_len != '0) && (sub_len <= MAX_LEN);
      owner_ok = (sub_slot == prod_slot) && fill_vec[sub_slot];
      accept   = sub_req && len_ok && owner_ok;
      acc_vec  = accept ? slot_onehot(sub_slot) : 2'b00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_slot <= 1'b0;
         sub_ack   <= 1'b0;
         sub_err   <= 1'b0;
      end else begin
         sub_ack <= accept;
         sub_err <= sub_req && !accept;
         if (accept) prod_slot <= ~prod_slot;
      end
   end

   AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sub_ack && sub_err)); // R4
   AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      sub_ack |-> $past(sub_req)); // R3
   AST_ERR_KEEPS_PROD: assert property (@(posedge clk) disable iff (!rst_n)
      sub_err |-> (prod_slot == $past(prod_slot))); // R4
endmodule

// File: rtl/tpp_slot.sv
module tpp_slot #(
   parameter int LEN_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              launch_i,
   input  logic              release_i,
   output tpp_pkg::slot_st_e state_o,
   output logic [LEN_W-1:0]  len_o
);
   import tpp_pkg::*;

   slot_st_e st_d;

   always_comb begin
      st_d = state_o;
      if (launch_i)       st_d = SL_SENDING;
      else if (release_i) st_d = SL_FILL;
      else if (take_i)    st_d = SL_QUEUED;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_o <= SL_FILL;
         len_o   <= '0;
      end else begin
         state_o <= st_d;
         if (take_i) len_o <= len_i;
      end
   end

   AST_SEND_FROM_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == SL_SENDING && $past(state_o) != SL_SENDING)
         |-> $past(state_o) == SL_QUEUED); // R6
   AST_RELEASE_ONLY_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |-> state_o == SL_SENDING); // R8
   AST_TAKE_ONLY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> state_o == SL_FILL); // R3
endmodule

// File: rtl/tpp_launch.sv
module tpp_launch #(
   parameter int          LEN_W  = 13,
   parameter int          ADDR_W = 15,
   parameter logic [ADDR_W-1:0] ADDR0 = '0,
   parameter logic [ADDR_W-1:0] ADDR1 = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            rdy_vec,
   input  logic [1:0][LEN_W-1:0] len_vec,
   input  logic                  tx_done,
   output logic [1:0]            go_vec,
   output logic [1:0]            fin_vec,
   output logic                  tx_start,
   output logic                  tx_slot,
   output logic [LEN_W-1:0]      tx_len,
   output logic [ADDR_W-1:0]     tx_addr,
   output logic                  tx_busy,
   output logic                  note_done,
   output logic                  note_slot
);
   import tpp_pkg::*;

   logic nxt;
   logic act_slot;
   logic done_ok;
   logic can_go;

   always_comb begin
      done_ok = tx_done && tx_busy;
      can_go  = (!tx_busy || done_ok) && rdy_vec[nxt];
      go_vec  = can_go  ? slot_onehot(nxt)      : 2'b00;
      fin_vec = done_ok ? slot_onehot(act_slot) : 2'b00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt       <= 1'b0;
         act_slot  <= 1'b0;
         tx_busy   <= 1'b0;
         tx_start  <= 1'b0;
         tx_slot   <= 1'b0;
         tx_len    <= '0;
         tx_addr   <= '0;
         note_done <= 1'b0;
         note_slot <= 1'b0;
      end else begin
         tx_start  <= can_go;
         note_done <= done_ok;
         if (done_ok) note_slot <= act_slot;
         if (can_go) begin
            tx_busy  <= 1'b1;
            act_slot <= nxt;
            nxt      <= ~nxt;
            tx_slot  <= nxt;
            tx_len   <= len_vec[nxt];
            tx_addr  <= nxt ? ADDR1 : ADDR0;
         end else if (done_ok) begin
            tx_busy <= 1'b0;
         end
      end
   end

   AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> (!$past(tx_busy) || $past(tx_done))); // R2
   AST_START0_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && !tx_slot) |-> $past(rdy_vec[0])); // R6
   AST_START1_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && tx_slot) |-> $past(rdy_vec[1])); // R6
   AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !tx_busy) |=> !note_done); // R10
endmodule

// File: rtl/tpp_ctrl.sv
module tpp_ctrl #(
   parameter int RAM_BYTES  = 32768,
   parameter int SLOT_BYTES = 4096,
   parameter int PING_BUF   = 0,
   parameter int PONG_BUF   = 1,
   localparam int NUM_BUF   = RAM_BYTES / SLOT_BYTES,
   localparam int ADDR_W    = $clog2(RAM_BYTES),
   localparam int LEN_W     = $clog2(SLOT_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_req,
   input  logic              sub_slot,
   input  logic [LEN_W-1:0]  sub_len,
   output logic              sub_ack,
   output logic              sub_err,
   output logic              prod_slot,
   output logic              tx_start,
   output logic              tx_slot,
   output logic [LEN_W-1:0]  tx_len,
   output logic [ADDR_W-1:0] tx_addr,
   input  logic              tx_done,
   output logic              tx_busy,
   output logic              note_done,
   output logic              note_slot
);
   import tpp_pkg::*;

   localparam logic [ADDR_W-1:0] ADDR0 = ADDR_W'(PING_BUF * SLOT_BYTES);
   localparam logic [ADDR_W-1:0] ADDR1 = ADDR_W'(PONG_BUF * SLOT_BYTES);

   if (RAM_BYTES % SLOT_BYTES != 0) begin : g_bad_div
      $error("RAM size must be a whole number of slots");
   end
   if (PING_BUF == PONG_BUF) begin : g_bad_same
      $error("the two slots must use distinct RAM buffers");
   end
   if (PING_BUF < 0 || PING_BUF >= NUM_BUF || PONG_BUF < 0 || PONG_BUF >= NUM_BUF) begin : g_bad_idx
      $error("slot buffer index outside the RAM");
   end

   logic [1:0]            acc_vec;
   logic [1:0]            go_vec;
   logic [1:0]            fin_vec;
   logic [1:0]            fill_vec;
   logic [1:0]            rdy_vec;
   logic [1:0]            send_vec;
   logic [1:0][LEN_W-1:0] len_vec;
   slot_st_e              st_vec [2];

   tpp_admit #(.LEN_W(LEN_W), .SLOT_BYTES(SLOT_BYTES)) admit_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sub_req   (sub_req),
      .sub_slot  (sub_slot),
      .sub_len   (sub_len),
      .fill_vec  (fill_vec),
      .acc_vec   (acc_vec),
      .sub_ack   (sub_ack),
      .sub_err   (sub_err),
      .prod_slot (prod_slot)
   );

   for (genvar s = 0; s < 2; s++) begin : g_slot
      tpp_slot #(.LEN_W(LEN_W)) slot_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .take_i    (acc_vec[s]),
         .len_i     (sub_len),
         .launch_i  (go_vec[s]),
         .release_i (fin_vec[s]),
         .state_o   (st_vec[s]),
         .len_o     (len_vec[s])
      );
      assign fill_vec[s] = (st_vec[s] == SL_FILL);
      assign rdy_vec[s]  = (st_vec[s] == SL_QUEUED);
      assign send_vec[s] = (st_vec[s] == SL_SENDING);
   end

   tpp_launch #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .ADDR0(ADDR0), .ADDR1(ADDR1)) launch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rdy_vec   (rdy_vec),
      .len_vec   (len_vec),
      .tx_done   (tx_done),
      .go_vec    (go_vec),
      .fin_vec   (fin_vec),
      .tx_start  (tx_start),
      .tx_slot   (tx_slot),
      .tx_len    (tx_len),
      .tx_addr   (tx_addr),
      .tx_busy   (tx_busy),
      .note_done (note_done),
      .note_slot (note_slot)
   );

   AST_ONE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(send_vec) <= 1); // R2
   AST_BUSY_MATCHES_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy == (send_vec != 2'b00)); // R2
   AST_SENDING_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_req && send_vec[sub_slot]) |=> sub_err); // R5
endmodule

// File: tb/tpp_ctrl_tb.sv
module tpp_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SLOT_BYTES = 4096;
   localparam int LEN_W = 13;
   localparam int ADDR_W = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sub_req = 1'b0;
   logic sub_slot = 1'b0;
   logic [LEN_W-1:0] sub_len = '0;
   logic tx_done = 1'b0;
   logic sub_ack, sub_err, prod_slot, tx_start, tx_slot, tx_busy, note_done, note_slot;
   logic [LEN_W-1:0] tx_len;
   logic [ADDR_W-1:0] tx_addr;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tpp_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .sub_req(sub_req), .sub_slot(sub_slot), .sub_len(sub_len),
      .sub_ack(sub_ack), .sub_err(sub_err), .prod_slot(prod_slot),
      .tx_start(tx_start), .tx_slot(tx_slot), .tx_len(tx_len), .tx_addr(tx_addr),
      .tx_done(tx_done), .tx_busy(tx_busy),
      .note_done(note_done), .note_slot(note_slot)
   );

   // ownership model: 0 producer-owned, 1 queued, 2 sending
   int m_st [2];
   int m_len [2];
   bit m_prod, m_busy, m_act, m_nxt;
   bit e_ack, e_err, e_start, e_tslot, e_note, e_nslot;
   int e_tlen;

   function automatic int addr_of(bit s);
      return (s ? 1 : 0) * SLOT_BYTES;
   endfunction

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_st[0] = 0; m_st[1] = 0; m_len[0] = 0; m_len[1] = 0;
      m_prod = 0; m_busy = 0; m_act = 0; m_nxt = 0;
   endtask

   task automatic model_step(bit req, bit slot, int len, bit done);
      bit ok, dok, go;
      ok  = req && (slot == m_prod) && (m_st[slot] == 0) && len >= 1 && len <= SLOT_BYTES;
      dok = done && m_busy;
      go  = (!m_busy || dok) && (m_st[m_nxt] == 1);
      e_ack = ok; e_err = req && !ok;
      e_note = dok; e_nslot = m_act;
      e_start = go; e_tslot = m_nxt; e_tlen = m_len[m_nxt];
      if (dok) m_st[m_act] = 0;
      if (ok) begin m_st[slot] = 1; m_len[slot] = len; m_prod = ~m_prod; end
      if (go) begin m_st[m_nxt] = 2; m_act = m_nxt; m_nxt = ~m_nxt; m_busy = 1; end
      else if (dok) m_busy = 0;
   endtask

   // one clock with the given inputs; compares all outputs after the edge
   task automatic step(bit req, bit slot, int len, bit done);
      sub_req = req; sub_slot = slot; sub_len = LEN_W'(len); tx_done = done;
      @(posedge clk);
      model_step(req, slot, len, done);
      @(negedge clk);
      chk("R3 sub_ack", sub_ack, e_ack);
      chk("R4 sub_err", sub_err, e_err);
      chk("R3 prod_slot", prod_slot, m_prod);
      chk("R2 tx_busy", tx_busy, m_busy);
      chk("R6 tx_start", tx_start, e_start);
      if (e_start && tx_start) begin
         chk("R7 tx_slot", tx_slot, e_tslot);
         chk("R6 tx_len", tx_len, e_tlen);
         chk("R6 tx_addr", tx_addr, addr_of(e_tslot));
      end
      chk("R8 note_done", note_done, e_note);
      if (e_note && note_done) chk("R8 note_slot", note_slot, e_nslot);
      sub_req = 0; tx_done = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h1d2c3b4a));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 prod_slot", prod_slot, 0);
      chk("R1 tx_busy", tx_busy, 0);
      chk("R1 tx_start", tx_start, 0);
      chk("R1 sub_ack", sub_ack, 0);
      chk("R1 sub_err", sub_err, 0);
      chk("R1 note_done", note_done, 0);

      // R4 wrong slot, then zero and oversize length
      step(1, 1, 100, 0);  chk("R4 wrong slot err", sub_err, 1);
      step(1, 0, 0, 0);    chk("R4 zero len err", sub_err, 1);
      step(1, 0, 4097, 0); chk("R4 oversize err", sub_err, 1);
      step(0, 0, 0, 0);    chk("R4 no start after reject", tx_start, 0);
      // R3 max length accepted, R6 start one cycle after ack
      step(1, 0, 4096, 0); chk("R3 ack", sub_ack, 1); chk("R3 prod toggled", prod_slot, 1);
      step(0, 0, 0, 0);    chk("R6 start", tx_start, 1); chk("R6 len", tx_len, 4096);
      chk("R6 addr slot0", tx_addr, 0);
      // R4 resubmit slot 0 while prod points at 1
      step(1, 0, 50, 0);   chk("R4 stale slot err", sub_err, 1);
      step(1, 1, 77, 0);   chk("R3 ack slot1", sub_ack, 1);
      step(0, 0, 0, 0);    chk("R2 no second start", tx_start, 0);
      // R5 slot 0 is sending
      step(1, 0, 10, 0);   chk("R5 sending slot err", sub_err, 1);
      // R9 restart right after done, R8 note names slot 0
      step(0, 0, 0, 1);
      chk("R8 note", note_done, 1); chk("R8 note slot0", note_slot, 0);
      chk("R9 start with note", tx_start, 1); chk("R7 slot1 next", tx_slot, 1);
      chk("R6 addr slot1", tx_addr, 4096); chk("R6 len 77", tx_len, 77);
      step(0, 0, 0, 1);    chk("R8 note slot1", note_slot, 1);
      step(0, 0, 0, 0);    chk("R2 idle", tx_busy, 0);
      // R10 stray done
      step(0, 0, 0, 1);
      step(0, 0, 0, 0);    chk("R10 no note", note_done, 0); chk("R10 still idle", tx_busy, 0);

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         bit req, sl, dn;
         int ln;
         req = ($urandom % 2) == 0;
         sl  = (($urandom % 10) < 8) ? m_prod : bit'($urandom % 2);
         ln  = (($urandom % 10) < 8) ? 1 + int'($urandom % SLOT_BYTES) : int'($urandom % 4200);
         dn  = m_busy ? (($urandom % 4) == 0) : (($urandom % 20) == 0);
         step(req, sl, ln, dn);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule